// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches two asynchronous modem-status lines, carrier detect and clear-to-send, together with a codec sync indication. It reports them to a CPU through a read-only status byte. Each line is brought into the clock domain through a two-stage synchronizer. A change of level is accepted only once it has held for a programmable number of baud sample ticks. The filter time is either one tick, which is 1/16 of a bit, or a full bit period.

An accepted change sets a sticky delta flag for that line. Reading the status byte clears both flags. A change accepted in the same cycle as the read is kept. A write-only control byte holds two interrupt enables, one per line. The registered interrupt output stays high while any enabled delta flag is set.

Top module: `modem_watch`

## Requirements
- R1: Each modem line passes through two flip-flops. The synchronized level appears on the status byte two clock edges after the pin changes: carrier detect at stat_o[1] and clear-to-send at stat_o[0], with 1 meaning high.
- R2: A delta flag is set only after the synchronized line has differed from its last accepted level on a given number of consecutive sample ticks. If the line returns to the accepted level first, the count restarts from zero.
- R3: With filt_long_i low the filter needs 1 tick. With filt_long_i high it needs TICKS_PER_BIT ticks (default 16). Cycles without tick_i never advance the filter.
- R4: A cycle with rd_stat_i high clears both delta flags after presenting them. A change accepted in that same cycle leaves its flag set.
- R5: Status layout: stat_o[7] is sync, stat_o[5] is the carrier-detect delta, stat_o[4] is the clear-to-send delta, and stat_o[1:0] are the levels. Bits 6, 3 and 2 always read 0.
- R6: stat_o[7] follows codec_mode_i AND sync_flag_i, registered once. It reads 0 when codec_mode_i is low.
- R7: A cycle with wr_ctl_i high loads the enables. wr_data_i[0] enables the clear-to-send delta and wr_data_i[1] enables the carrier-detect delta. wr_data_i[7:2] are ignored, and both enables reset to 0.
- R8: irq_o is high one clock after (carrier delta AND its enable) OR (clear-to-send delta AND its enable) is true. It stays high until that term clears.
- R9: During reset the accepted levels load from the synchronized lines. After reset no delta flag is set and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Baud sample tick (16 per bit) |
| filt_long_i | input | 1 | Filter select: 0 = one tick, 1 = full bit |
| codec_mode_i | input | 1 | Codec mode active |
| sync_flag_i | input | 1 | Codec frame/sync indication |
| dcd_async_i | input | 1 | Carrier detect line, asynchronous |
| cts_async_i | input | 1 | Clear-to-send line, asynchronous |
| rd_stat_i | input | 1 | Status byte read strobe |
| stat_o | output | 8 | Status byte |
| wr_ctl_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte write data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps pulse widths from 1 to 20 ticks on both lines in both filter modes. This catches an off-by-one filter that accepts a pulse one tick short or rejects one exactly at the limit. It also sends two near-threshold pulses separated by a one-cycle return, which a filter that fails to restart would accept. A read issued in the very cycle a change is accepted exposes a clear that wins over the set. Single-line enables and tick-free hold periods show interrupts that ignore their enable and filters that count clock cycles instead of ticks.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int NLINES = 2;
  localparam int LN_CTS = 0;
  localparam int LN_DCD = 1;
  localparam int ST_SYNC = 7;
  localparam int ST_DDCD = 5;
  localparam int ST_DCTS = 4;
  localparam int ST_LDCD = 1;
  localparam int ST_LCTS = 0;
endpackage

// File: rtl/mw_sync2.sv
module mw_sync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1, s2;
  always_ff @(posedge clk) begin
    s1 <= d_i;
    s2 <= s1;
  end
  assign q_o = s2;
endmodule

// File: rtl/mw_glitch_filter.sv
module mw_glitch_filter #(
  parameter int LONG_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic long_i,
  input  logic lvl_i,
  output logic chg_o,
  output logic acc_o
);
  localparam int CW = $clog2(LONG_TICKS + 1);
  localparam logic [CW-1:0] LIM_L = CW'(LONG_TICKS - 1);
  localparam logic [CW-1:0] LIM_S = '0;

  logic          acc;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          differs;

  assign lim     = long_i ? LIM_L : LIM_S;
  assign differs = (lvl_i != acc);
  assign chg_o   = differs && tick_i && (cnt == lim);
  assign acc_o   = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= lvl_i;
      cnt <= '0;
    end else if (!differs) begin
      cnt <= '0;
    end else if (tick_i) begin
      if (cnt == lim) begin
        acc <= lvl_i;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/modem_watch.sv
module modem_watch #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       filt_long_i,
  input  logic       codec_mode_i,
  input  logic       sync_flag_i,
  input  logic       dcd_async_i,
  input  logic       cts_async_i,
  input  logic       rd_stat_i,
  output logic [7:0] stat_o,
  input  logic       wr_ctl_i,
  input  logic [7:0] wr_data_i,
  output logic       irq_o
);
  import mw_pkg::*;

  logic [NLINES-1:0] raw, lvl, chg, acc;
  logic [NLINES-1:0] delta_q, en_q;
  logic              sync_q, irq_q;

  assign raw[LN_CTS] = cts_async_i;
  assign raw[LN_DCD] = dcd_async_i;

  mw_sync2 #(.WIDTH(NLINES)) u_sync (
    .clk (clk),
    .d_i (raw),
    .q_o (lvl)
  );

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    mw_glitch_filter #(.LONG_TICKS(TICKS_PER_BIT)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .tick_i (tick_i),
      .long_i (filt_long_i),
      .lvl_i  (lvl[g]),
      .chg_o  (chg[g]),
      .acc_o  (acc[g])
    );

    always_ff @(posedge clk) begin
      if (rst) delta_q[g] <= 1'b0;
      else     delta_q[g] <= (delta_q[g] & ~rd_stat_i) | chg[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      sync_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctl_i) en_q <= wr_data_i[NLINES-1:0];
      sync_q <= codec_mode_i & sync_flag_i;
      irq_q  <= |(delta_q & en_q);
    end
  end

  always_comb begin
    stat_o          = '0;
    stat_o[ST_SYNC] = sync_q;
    stat_o[ST_DDCD] = delta_q[LN_DCD];
    stat_o[ST_DCTS] = delta_q[LN_CTS];
    stat_o[ST_LDCD] = lvl[LN_DCD];
    stat_o[ST_LCTS] = lvl[LN_CTS];
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/mw_check.sv
module mw_check (
  input logic       clk,
  input logic       rst,
  input logic       codec_mode_i,
  input logic       dcd_async_i,
  input logic       rd_stat_i,
  input logic [7:0] stat_o,
  input logic       irq_o,
  input logic [1:0] chg
);
  a_r9_reset_quiet: assert property (@(posedge clk)
    $fell(rst) |-> (stat_o[5:4] == 2'b00 && !irq_o));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_stat_i && !chg[1]) |=> !stat_o[5]);

  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    (stat_o[5] && !rd_stat_i) |=> stat_o[5]);

  a_r4_change_wins: assert property (@(posedge clk) disable iff (rst)
    chg[0] |=> stat_o[4]);

  a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(stat_o[5] || stat_o[4]));

  a_r6_sync_off: assert property (@(posedge clk) disable iff (rst)
    !codec_mode_i |=> !stat_o[7]);

  a_r1_two_stage: assert property (@(posedge clk) disable iff (rst)
    $past(rst, 2) == 1'b0 |-> stat_o[1] == $past(dcd_async_i, 2));
endmodule

bind modem_watch mw_check u_chk (
  .clk          (clk),
  .rst          (rst),
  .codec_mode_i (codec_mode_i),
  .dcd_async_i  (dcd_async_i),
  .rd_stat_i    (rd_stat_i),
  .stat_o       (stat_o),
  .irq_o        (irq_o),
  .chg          (chg)
);

// File: tb/modem_watch_bench.sv
`timescale 1ns/1ps
module modem_watch_bench;
  localparam int TPB = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1, flong = 1'b0, cmode = 1'b0, sflag = 1'b0;
  logic dcd = 1'b1, cts = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] stat;
  logic irq;
  int errs = 0, checks = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  modem_watch #(.TICKS_PER_BIT(TPB)) u_modem_watch (
    .clk(clk), .rst(rst), .tick_i(tick), .filt_long_i(flong),
    .codec_mode_i(cmode), .sync_flag_i(sflag), .dcd_async_i(dcd),
    .cts_async_i(cts), .rd_stat_i(rd), .stat_o(stat), .wr_ctl_i(wr),
    .wr_data_i(wdata), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_stat(output logic [7:0] r);
    @(negedge clk); r = stat; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    wait_n(5);
    rst = 1'b0;
    @(negedge clk);
    // R9 / R5: levels carried, no deltas, reserved zero
    chk("R9 reset status", stat, 8'h02);
    chk("R9 reset irq", irq, 0);

    // R1: two-edge level latency
    @(negedge clk); cts = 1'b1;
    @(negedge clk); chk("R1 level after one edge", stat[0], 0);
    @(negedge clk); chk("R1 level after two edges", stat[0], 1);
    wait_n(5);
    read_stat(v);
    chk("R5 cts delta bit", v, 8'h13);
    read_stat(v);
    chk("R4 cleared after read", v[5:4], 0);

    // R2 / R3: pulse-width sweep
    for (int sel = 0; sel < 2; sel++) begin
      flong = sel[0];
      for (int ln = 0; ln < 2; ln++) begin
        for (int w = 1; w <= 20; w++) begin
          int lim;
          lim = sel ? TPB : 1;
          @(negedge clk);
          if (ln == 0) cts = ~cts; else dcd = ~dcd;
          wait_n(w);
          if (ln == 0) cts = ~cts; else dcd = ~dcd;
          wait_n(25);
          read_stat(v);
          chk(sel ? "R3 long filter sweep" : "R2 short filter sweep",
              ln ? v[5] : v[4], (w >= lim) ? 1 : 0);
        end
      end
    end

    // R2: restart on return
    flong = 1'b1;
    @(negedge clk); dcd = ~dcd; wait_n(TPB - 2);
    dcd = ~dcd; wait_n(1);
    dcd = ~dcd; wait_n(TPB - 2);
    dcd = ~dcd; wait_n(25);
    read_stat(v);
    chk("R2 restart after return", v[5], 0);

    // R3: ticks gate the filter
    tick = 1'b0;
    @(negedge clk); cts = ~cts; wait_n(40);
    chk("R3 no ticks no delta", stat[4], 0);
    tick = 1'b1; wait_n(TPB + 3);
    chk("R3 ticks complete filter", stat[4], 1);
    read_stat(v);

    // R4: change accepted in same cycle as read
    flong = 1'b0;
    @(negedge clk); cts = ~cts;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk("R4 change survives read", stat[4], 1);
    read_stat(v);

    // R7 / R8: enables and interrupt
    @(negedge clk); wr = 1'b1; wdata = 8'h01;
    @(negedge clk); wr = 1'b0;
    dcd = ~dcd; wait_n(25);
    chk("R7 dcd delta not enabled", irq, 0);
    cts = ~cts; wait_n(25);
    chk("R8 irq from cts delta", irq, 1);
    @(negedge clk); wr = 1'b1; wdata = 8'hFC;
    @(negedge clk); wr = 1'b0;
    @(negedge clk);
    chk("R7 upper bits ignored", irq, 0);
    @(negedge clk); wr = 1'b1; wdata = 8'hFE;
    @(negedge clk); wr = 1'b0;
    @(negedge clk);
    chk("R7 dcd enable", irq, 1);
    read_stat(v);
    @(negedge clk);
    chk("R8 irq drops after clear", irq, 0);

    // R6: sync bit
    cmode = 1'b0; sflag = 1'b1; wait_n(2);
    chk("R6 sync off outside codec", stat[7], 0);
    cmode = 1'b1; @(negedge clk);
    chk("R6 sync shown in codec", stat[7], 1);
    sflag = 1'b0; @(negedge clk);
    chk("R6 sync follows flag", stat[7], 0);

    finish_run();
  end
endmodule